// File: doc/BRIEF.md
# Pipelined Multi-Operand Adder Tree

This block adds a parameterised number of unsigned operands of equal width and returns their exact total. The operands arrive together as one flat vector with a valid flag. Internally the operands pass through a binary reduction tree. Each tree level has its own register, so the block accepts a new operand set on every clock and returns one total per accepted set, after a fixed delay.

At each level, neighbouring operands (indices 2k and 2k+1) are summed into a result one bit wider. When the operand count at a level is odd, the highest-index operand has no partner. It is zero-extended and carried to the next level unchanged. The tree therefore has ceil(log2 N) levels, and the final total is that many bits wider than one operand. For example, nine 8-bit operands reduce as 9 → 5 → 3 → 2 → 1, and the result is 12 bits wide. A valid flag travels alongside the data. Each level loads only when its valid is high, so idle cycles leave the pipeline contents untouched.

The reset input is asserted asynchronously. It is released through a two-stage synchroniser. A design that needs to add many sensor samples, filter taps or partial products in a single stream can place this block directly in its datapath.

Top module: `adder_tree_pipe`

## Requirements
- R1: When out_valid is 1, out_sum equals the arithmetic sum of all N_OPS operands of the accepted input. Operand i occupies in_data[i*OP_W +: OP_W]. out_sum is OP_W + ceil(log2 N_OPS) bits wide, which is 12 bits for the defaults N_OPS=9, OP_W=8.
- R2: out_valid equals the accepted in_valid delayed by exactly ceil(log2 N_OPS) clock cycles (4 for the defaults). Inputs accepted on consecutive cycles yield results on consecutive cycles.
- R3: The result never overflows. With every operand at its maximum value 2^OP_W-1, out_sum equals N_OPS*(2^OP_W-1), which is 2295 for the defaults.
- R4: Operands are paired by index, and an unpaired highest-index operand is zero-extended and forwarded. A set in which only one operand is non-zero, in any position including the last, yields that operand's value after the same latency.
- R5: Driving rst_n low clears out_valid and out_sum to 0 at once, without waiting for a clock edge. They stay 0 while rst_n is low.
- R6: After rst_n rises, in_valid is ignored at the first two rising clock edges. Input is accepted from the third edge on.
- R7: While out_valid is 0, out_sum keeps the most recent result, or 0 if there has been no result since reset. Operand values presented with in_valid=0 never reach the output.
- R8: With N_OPS=1 the single operand appears on out_sum with no widening (width OP_W), one cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low, asserted asynchronously, released through a synchroniser |
| in_valid | input | 1 | Operand set on in_data is to be summed |
| in_data | input | N_OPS*OP_W | Flat operand vector; operand i at bits i*OP_W +: OP_W |
| out_valid | output | 1 | out_sum holds a new total |
| out_sum | output | OP_W+ceil(log2 N_OPS) | Total of the operand set accepted ceil(log2 N_OPS) cycles earlier |

## Verification
The bench targets these faults and their symptoms:
- Overflow: all-maximum operands expose a level that does not widen, which returns a wrapped total.
- Lost or misplaced leftover: sets with a single non-zero operand in the first, a middle or the last position expose a tree that drops the odd leftover or pairs the wrong indices. Such a design returns 0 or a wrong total.
- Wrong delay or leaking idle data: random streams, both back-to-back and with idle gaps, are compared against an independent delay model. A wrong latency shows as mismatched valid timing. Idle-cycle data that leaks through shows as a changed held total.
- Reset faults: a reset fired in mid-stream with the pipeline full must clear the outputs before the next edge. Input presented in the two edges after release must vanish.

A second instance with one operand covers the pass-through case.

// File: rtl/adt_pkg.sv
package adt_pkg;

  // Bits needed to index n items (ceil(log2(n))), 0 for n <= 1.
  function automatic int adt_clog2(input int n);
    int r;
    int m;
    r = 0;
    m = n - 1;
    while (m > 0) begin
      r = r + 1;
      m = m >> 1;
    end
    return r;
  endfunction

  // Operand count after lvl reduction levels starting from n operands.
  function automatic int adt_ops_at(input int n, input int lvl);
    int c;
    c = n;
    for (int k = 0; k < lvl; k++) begin
      c = (c + 1) / 2;
    end
    return c;
  endfunction

endpackage

// File: rtl/adt_rst_sync.sv
module adt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/adt_valid_pipe.sv
module adt_valid_pipe #(
  parameter int STAGES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_v,
  output logic [STAGES:0] taps
);

  logic [STAGES-1:0] vq;

  assign taps = {vq, in_v};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq <= '0;
    end else begin
      vq <= taps[STAGES-1:0];
    end
  end

  // R2: each valid stage is the previous one delayed by one clock
  for (genvar j = 0; j < STAGES; j++) begin : g_chk
    a_r2_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (vq[j] == $past(taps[j])));
  end

endmodule

// File: rtl/adt_level.sv
module adt_level
  import adt_pkg::*;
#(
  parameter int N_IN = 9,
  parameter int W_IN = 8,
  parameter int GROW = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  logic [N_IN*W_IN-1:0]            ops_i,
  output logic [((N_IN+1)/2)*(W_IN+GROW)-1:0] ops_o
);

  localparam int N_OUT = (N_IN + 1) / 2;
  localparam int W_OUT = W_IN + GROW;
  localparam int PAIRS = N_IN / 2;
  localparam int ODD   = N_IN % 2;
  localparam int TOT_W = W_IN + adt_clog2(N_IN) + 1;

  logic [W_OUT-1:0]       sum_d [N_OUT];
  logic [N_OUT*W_OUT-1:0] sum_flat;
  logic [N_OUT*W_OUT-1:0] sum_q;

  // next state: neighbour pairs, one bit wider
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign sum_d[p] = W_OUT'(ops_i[2*p*W_IN +: W_IN])
                    + W_OUT'(ops_i[(2*p+1)*W_IN +: W_IN]);
  end

  // unpaired highest operand is zero-extended and forwarded
  if (ODD == 1) begin : g_odd
    assign sum_d[N_OUT-1] = W_OUT'(ops_i[(N_IN-1)*W_IN +: W_IN]);

    a_r4_odd_forward: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (ops_o[(N_OUT-1)*W_OUT +: W_OUT] ==
              W_OUT'($past(ops_i[(N_IN-1)*W_IN +: W_IN]))));
  end

  always_comb begin
    for (int j = 0; j < N_OUT; j++) begin
      sum_flat[j*W_OUT +: W_OUT] = sum_d[j];
    end
  end

  // register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (en) begin
      sum_q <= sum_flat;
    end
  end

  assign ops_o = sum_q;

  function automatic logic [TOT_W-1:0] tot_in(input logic [N_IN*W_IN-1:0] v);
    logic [TOT_W-1:0] t;
    t = '0;
    for (int i = 0; i < N_IN; i++) t = t + TOT_W'(v[i*W_IN +: W_IN]);
    return t;
  endfunction

  function automatic logic [TOT_W-1:0] tot_out(input logic [N_OUT*W_OUT-1:0] v);
    logic [TOT_W-1:0] t;
    t = '0;
    for (int i = 0; i < N_OUT; i++) t = t + TOT_W'(v[i*W_OUT +: W_OUT]);
    return t;
  endfunction

  // R1: a level never changes the total it carries
  a_r1_total_kept: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (tot_out(ops_o) == $past(tot_in(ops_i))));

  // R7: an idle level keeps its contents
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ops_o));

endmodule

// File: rtl/adder_tree_pipe.sv
module adder_tree_pipe
  import adt_pkg::*;
#(
  parameter int N_OPS = 9,
  parameter int OP_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [N_OPS*OP_W-1:0]   in_data,
  output logic                    out_valid,
  output logic [OP_W+adt_clog2(N_OPS)-1:0] out_sum
);

  localparam int LVLS = (N_OPS == 1) ? 1 : adt_clog2(N_OPS);
  localparam int GROW = (N_OPS == 1) ? 0 : 1;

  logic          rst_ni;
  logic [LVLS:0] stage_v;

  adt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  adt_valid_pipe #(.STAGES(LVLS)) u_vpipe (
    .clk   (clk),
    .rst_n (rst_ni),
    .in_v  (in_valid),
    .taps  (stage_v)
  );

  for (genvar k = 0; k < LVLS; k++) begin : g_lvl
    localparam int CI = adt_ops_at(N_OPS, k);
    localparam int CO = adt_ops_at(N_OPS, k + 1);
    localparam int WI = OP_W + k * GROW;
    localparam int WO = WI + GROW;

    logic [CI*WI-1:0] lvl_d;
    logic [CO*WO-1:0] lvl_q;

    if (k == 0) begin : g_src
      assign lvl_d = in_data;
    end else begin : g_src
      assign lvl_d = g_lvl[k-1].lvl_q;
    end

    adt_level #(.N_IN(CI), .W_IN(WI), .GROW(GROW)) u_lvl (
      .clk   (clk),
      .rst_n (rst_ni),
      .en    (stage_v[k]),
      .ops_i (lvl_d),
      .ops_o (lvl_q)
    );
  end

  assign out_sum   = g_lvl[LVLS-1].lvl_q;
  assign out_valid = stage_v[LVLS];

  // R5: while the internal reset is low nothing is presented
  a_r5_reset_clear: assert property (@(posedge clk)
    !rst_ni |-> (!out_valid && (out_sum == '0)));

endmodule

// File: tb/adder_tree_pipe_tb.sv
module adder_tree_pipe_tb;

  localparam int N  = 9;
  localparam int W  = 8;
  localparam int L  = 4;
  localparam int SW = 12;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [N*W-1:0] in_data;
  logic           out_valid;
  logic [SW-1:0]  out_sum;
  logic           out_valid1;
  logic [W-1:0]   out_sum1;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adder_tree_pipe #(.N_OPS(N), .OP_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_sum(out_sum)
  );

  adder_tree_pipe #(.N_OPS(1), .OP_W(W)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data[W-1:0]),
    .out_valid(out_valid1), .out_sum(out_sum1)
  );

  // bench model
  logic          mv [1:L];
  logic [SW-1:0] ms [1:L];
  logic [SW-1:0] last_s;
  logic          mv1;
  logic [W-1:0]  last1;
  int            ign_cnt;

  function automatic logic [SW-1:0] ref_sum(input logic [N*W-1:0] d);
    logic [SW-1:0] t;
    t = '0;
    for (int i = 0; i < N; i++) t = t + SW'(d[i*W +: W]);
    return t;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int k = 1; k <= L; k++) begin
      mv[k] = 1'b0;
      ms[k] = '0;
    end
    last_s = '0;
    mv1 = 1'b0;
    last1 = '0;
  endtask

  // one clock: drive at negedge, update model at posedge, check at next negedge
  task automatic cycle(input logic v, input logic [N*W-1:0] d, input string tag);
    logic acc;
    logic [SW-1:0] exp_s;
    in_valid = v;
    in_data  = d;
    @(posedge clk);
    acc = v && (ign_cnt == 0) && rst_n;
    if (ign_cnt > 0) ign_cnt--;
    for (int k = L; k >= 2; k--) begin
      mv[k] = mv[k-1];
      ms[k] = ms[k-1];
    end
    mv[1] = acc;
    ms[1] = ref_sum(d);
    mv1 = acc;
    if (acc) last1 = d[W-1:0];
    if (mv[L]) last_s = ms[L];
    exp_s = last_s;
    @(negedge clk);
    check({tag, "/R2 valid"}, 64'(out_valid), 64'(mv[L]));
    check({tag, " sum"}, 64'(out_sum), 64'(exp_s));
    check("R8 valid", 64'(out_valid1), 64'(mv1));
    check("R8 sum", 64'(out_sum1), 64'(last1));
  endtask

  task automatic do_reset();
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1;
    check("R5 async valid", 64'(out_valid), 64'd0);
    check("R5 async sum", 64'(out_sum), 64'd0);
    check("R5 async n1", 64'(out_sum1), 64'd0);
    model_clear();
    @(negedge clk);
    for (int i = 0; i < 3; i++) cycle(1'b1, {N*W{1'b1}}, "R5");
    rst_n = 1'b1;
    ign_cnt = 2;
  endtask

  function automatic logic [N*W-1:0] rand_data();
    logic [N*W-1:0] d;
    for (int i = 0; i < N; i++) d[i*W +: W] = W'($urandom);
    return d;
  endfunction

  initial begin
    logic [N*W-1:0] d;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    ign_cnt = 0;
    model_clear();
    @(negedge clk);
    for (int i = 0; i < 3; i++) cycle(1'b0, '0, "R5");
    check("R5 reset valid", 64'(out_valid), 64'd0);
    check("R5 reset sum", 64'(out_sum), 64'd0);
    rst_n = 1'b1;
    ign_cnt = 2;

    // R6: two edges after release are ignored
    cycle(1'b1, {N*W{1'b1}}, "R6");
    cycle(1'b1, {N*W{1'b1}}, "R6");
    for (int i = 0; i < L + 1; i++) cycle(1'b0, '0, "R6");
    check("R6 nothing accepted", 64'(out_sum), 64'd0);

    // R3: all operands at maximum
    cycle(1'b1, {N*W{1'b1}}, "R3");
    for (int i = 0; i < L; i++) cycle(1'b0, '0, "R3");
    check("R3 max total", 64'(out_sum), 64'd2295);

    // R4: single non-zero operand in each position
    for (int p = 0; p < N; p++) begin
      d = '0;
      d[p*W +: W] = W'(8'hA5 ^ p);
      cycle(1'b1, d, "R4");
    end
    d = '0;
    d[0 +: W] = 8'd17;
    d[W +: W] = 8'd200;
    cycle(1'b1, d, "R4");
    for (int i = 0; i < L; i++) cycle(1'b0, '0, "R4");
    check("R4 pair 0+1", 64'(out_sum), 64'd217);

    // R1/R2: back-to-back random
    for (int i = 0; i < 200; i++) cycle(1'b1, rand_data(), "R1");

    // R7: random with idle gaps; idle data is junk
    for (int i = 0; i < 300; i++) cycle(1'($urandom % 2), rand_data(), "R7");
    for (int i = 0; i < L + 2; i++) cycle(1'b0, rand_data(), "R7");

    // R5: reset with pipeline full, then resume
    for (int i = 0; i < L; i++) cycle(1'b1, rand_data(), "R1");
    do_reset();
    cycle(1'b1, rand_data(), "R6");
    cycle(1'b1, rand_data(), "R6");
    for (int i = 0; i < 100; i++) cycle(1'($urandom % 4 != 0), rand_data(), "R1");
    for (int i = 0; i < L + 1; i++) cycle(1'b0, '0, "R7");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

endmodule